// File: doc/BRIEF.md
# Shared Interrupt Routing Register Bank

This block holds one 64-bit routing register for every shared interrupt. Software writes a three-level processor affinity into the register of an interrupt. The bank keeps the 24 affinity bits and turns them into the index of the core whose affinity matches. Each shared interrupt has a target output made of a core index and a valid flag, which the delivery logic downstream reads.

The register space is flat at eight bytes per interrupt number and has no gaps. The slots below the first shared number exist but are inert. The upper word of every register is inert too, because no fourth affinity level is kept. Numbers at or beyond the configured count are also inert. Accesses are 32 or 64 bits wide. Read data comes out one cycle after the request and holds until the next read. A write takes effect at the clock edge where it is presented, and the target of that interrupt is resolved at the same edge against the core affinity table.

Top module: `irq_route_bank`

## Requirements
- R1: Interrupt number n occupies the eight bytes at byte address 8*n; a write to address 8*n followed by a read of 8*n returns the value stored for n only.
- R2: Addresses of interrupt numbers below NUM_PRIV (default 32) read as zero, and writes to them change no register and no target.
- R3: An access with address bit 2 set (upper word) reads as zero, and a write there changes neither the stored affinity nor the target.
- R4: A write keeps only write-data bits [23:0]; bits [63:24] of any read are zero.
- R5: A write to a shared interrupt sets its target index to the core whose 24-bit table entry (core c at coreAff bits [24*c+23:24*c]) equals the stored value, with the valid flag 1, visible right after the write's clock edge.
- R6: If no core entry matches the written affinity, the target valid flag of that interrupt is 0.
- R7: If several core entries match, the lowest core index is chosen.
- R8: A read returns the stored value zero-extended to 64 bits and shifted right by 8 times address bits [2:0]; a 32-bit read (is64 = 0) returns only the low 32 bits of that, with bits [63:32] zero.
- R9: Interrupt numbers at or above NUM_IRQ read as zero, and writes to them change no register and no target.
- R10: After reset all affinities are zero and rdData is zero. In the first clock cycle after reset is released, every target is resolved against affinity zero.
- R11: Read data is registered: it changes one clock edge after a cycle with rdEn high and holds while rdEn is low, even if a write changes the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read request this cycle |
| wrEn | input | 1 | Write request this cycle |
| is64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| addr | input | ADDR_W | Byte address within the bank |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Registered read data |
| coreAff | input | NUM_CORES*24 | Affinity of each core, core c at bits [24*c+23:24*c] |
| tgtIdx | output | (NUM_IRQ-NUM_PRIV)*IDX_W | Target core per shared interrupt, interrupt NUM_PRIV+j at field j |
| tgtValid | output | NUM_IRQ-NUM_PRIV | Target valid per shared interrupt, bit j for interrupt NUM_PRIV+j |

## Verification
The assertions check on every cycle that writes to private slots, upper words and out-of-range numbers never become internal write strobes. They also check that an inert read returns zero, that read data holds between reads, that its top 40 bits stay zero, that a resolved write target really matches its table entry, and that the post-reset resolve lasts one cycle. Only the bench scenarios can show the end-to-end results. These are the stored value coming back at the right address, the byte shifting by offset, the lowest-index choice among duplicate core entries, the invalid flag when nothing matches, and the targets every shared interrupt gets after reset.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int AFF_W      = 24;
  localparam int SLOT_MAX_W = 16;

  // Decoded access handed from control to datapath
  typedef struct packed {
    logic                  wrEn;
    logic                  rdEn;
    logic                  zeroRd;
    logic                  is64;
    logic [2:0]            byteOff;
    logic [SLOT_MAX_W-1:0] slot;
  } routeStrobe_t;
endpackage

// File: rtl/irq_route_match.sv
module irq_route_match #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2
) (
  input  logic [irq_route_pkg::AFF_W-1:0]           key,
  input  logic [NUM_CORES*irq_route_pkg::AFF_W-1:0] coreAff,
  output logic [IDX_W-1:0]                          idx,
  output logic                                      hit
);
  import irq_route_pkg::*;

  logic [NUM_CORES-1:0] hitVec;

  genvar c;
  generate
    for (c = 0; c < NUM_CORES; c++) begin : gCmp
      assign hitVec[c] = (coreAff[c*AFF_W +: AFF_W] == key);
    end
  endgenerate

  // lowest matching core index wins
  always_comb begin
    idx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (hitVec[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |hitVec;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32,
  parameter int ADDR_W   = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rdEn,
  input  logic                        wrEn,
  input  logic                        is64,
  input  logic [ADDR_W-1:0]           addr,
  output irq_route_pkg::routeStrobe_t stb,
  output logic                        initResolve
);
  import irq_route_pkg::*;

  localparam int IRQ_W = ADDR_W - 3;

  logic [IRQ_W-1:0] irqNum;
  logic             upperWord;
  logic             isPriv;
  logic             isBeyond;
  logic             liveSlot;
  logic             initDone;

  assign irqNum    = addr[ADDR_W-1:3];
  assign upperWord = addr[2];
  assign isPriv    = (32'(irqNum) < NUM_PRIV);
  assign isBeyond  = (32'(irqNum) >= NUM_IRQ);
  assign liveSlot  = !isPriv && !isBeyond && !upperWord;

  always_comb begin
    stb.wrEn    = wrEn && liveSlot;
    stb.rdEn    = rdEn;
    stb.zeroRd  = !liveSlot;
    stb.is64    = is64;
    stb.byteOff = addr[2:0];
    stb.slot    = SLOT_MAX_W'(irqNum) - SLOT_MAX_W'(NUM_PRIV);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initDone <= 1'b0;
    else       initDone <= 1'b1;
  end

  assign initResolve = !initDone;

  AST_PRIV_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isPriv) |-> !stb.wrEn); // R2
  AST_UPPER_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[2]) |-> !stb.wrEn); // R3
  AST_RANGE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isBeyond) |-> !stb.wrEn); // R9
  AST_INIT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    initResolve |=> !initResolve); // R10
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp #(
  parameter int NUM_SHARED = 32,
  parameter int NUM_CORES  = 4,
  parameter int IDX_W      = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  irq_route_pkg::routeStrobe_t               stb,
  input  logic                                      initResolve,
  input  logic [irq_route_pkg::AFF_W-1:0]           wrAff,
  input  logic [NUM_CORES*irq_route_pkg::AFF_W-1:0] coreAff,
  output logic [63:0]                               rdData,
  output logic [NUM_SHARED*IDX_W-1:0]               tgtIdx,
  output logic [NUM_SHARED-1:0]                     tgtValid
);
  import irq_route_pkg::*;

  localparam int SLOT_W = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;

  logic [AFF_W-1:0] affReg  [NUM_SHARED];
  logic [IDX_W-1:0] idxReg  [NUM_SHARED];
  logic             valReg  [NUM_SHARED];

  logic [SLOT_W-1:0] slotSel;
  logic              unusedSlotHi;
  logic [IDX_W-1:0]  wIdx;
  logic              wHit;
  logic [IDX_W-1:0]  zIdx;
  logic              zHit;
  logic [63:0]       fullVal;
  logic [63:0]       shifted;
  logic [63:0]       rdNext;

  assign slotSel      = stb.slot[SLOT_W-1:0];
  assign unusedSlotHi = |(stb.slot >> SLOT_W);

  // resolver for the incoming write value
  irq_route_match #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) uWrMatch (
    .key(wrAff), .coreAff(coreAff), .idx(wIdx), .hit(wHit)
  );

  // resolver for the reset value, shared by every slot
  irq_route_match #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) uZeroMatch (
    .key('0), .coreAff(coreAff), .idx(zIdx), .hit(zHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SHARED; s++) begin
        affReg[s] <= '0;
        idxReg[s] <= '0;
        valReg[s] <= 1'b0;
      end
    end else begin
      if (initResolve) begin
        for (int s = 0; s < NUM_SHARED; s++) begin
          idxReg[s] <= zIdx;
          valReg[s] <= zHit;
        end
      end
      if (stb.wrEn) begin
        affReg[slotSel] <= wrAff;
        idxReg[slotSel] <= wIdx;
        valReg[slotSel] <= wHit;
      end
    end
  end

  always_comb begin
    fullVal = {{(64 - AFF_W){1'b0}}, affReg[slotSel]};
    shifted = fullVal >> {stb.byteOff, 3'b000};
    if (stb.zeroRd)     rdNext = '0;
    else if (stb.is64)  rdNext = shifted;
    else                rdNext = {32'h0, shifted[31:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
  end

  genvar j;
  generate
    for (j = 0; j < NUM_SHARED; j++) begin : gOut
      assign tgtIdx[j*IDX_W +: IDX_W] = idxReg[j];
      assign tgtValid[j]              = valReg[j];
    end
  endgenerate

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.zeroRd) |=> (rdData == 64'h0)); // R2
  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |=> (rdData[63:AFF_W] == '0)); // R4
  AST_WR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && wHit) |-> (coreAff[int'(wIdx)*AFF_W +: AFF_W] == wrAff)); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(rdData)); // R11
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank #(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_PRIV  = 32,
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10,
  localparam int NUM_SHARED = NUM_IRQ - NUM_PRIV,
  localparam int IDX_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rdEn,
  input  logic                        wrEn,
  input  logic                        is64,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [63:0]                 wrData,
  output logic [63:0]                 rdData,
  input  logic [NUM_CORES*24-1:0]     coreAff,
  output logic [NUM_SHARED*IDX_W-1:0] tgtIdx,
  output logic [NUM_SHARED-1:0]       tgtValid
);
  import irq_route_pkg::*;

  routeStrobe_t stb;
  logic         initResolve;
  logic         unusedWrHi;

  assign unusedWrHi = ^wrData[63:AFF_W];

  irq_route_ctrl #(.NUM_IRQ(NUM_IRQ), .NUM_PRIV(NUM_PRIV), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .is64(is64),
    .addr(addr), .stb(stb), .initResolve(initResolve)
  );

  irq_route_dp #(.NUM_SHARED(NUM_SHARED), .NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .initResolve(initResolve),
    .wrAff(wrData[AFF_W-1:0]), .coreAff(coreAff),
    .rdData(rdData), .tgtIdx(tgtIdx), .tgtValid(tgtValid)
  );
endmodule

// File: tb/sim_irq_route_bank.sv
`timescale 1ns/1ps
module sim_irq_route_bank;
  localparam int NUM_IRQ = 64, NUM_PRIV = 32, NUM_CORES = 4, ADDR_W = 10, IDX_W = 2;
  localparam int NSH = NUM_IRQ - NUM_PRIV;

  logic clk = 0, rstN = 0, rdEn = 0, wrEn = 0, is64 = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [63:0] wrData = '0, rdData;
  logic [NUM_CORES*24-1:0] coreAff;
  logic [NSH*IDX_W-1:0] tgtIdx;
  logic [NSH-1:0] tgtValid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  // core0 0x010203, core1 0x000000, core2 and core3 both 0x0A0B0C
  assign coreAff = {24'h0A0B0C, 24'h0A0B0C, 24'h000000, 24'h010203};

  irq_route_bank #(.NUM_IRQ(NUM_IRQ), .NUM_PRIV(NUM_PRIV), .NUM_CORES(NUM_CORES),
                   .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .is64(is64), .addr(addr),
    .wrData(wrData), .rdData(rdData), .coreAff(coreAff), .tgtIdx(tgtIdx),
    .tgtValid(tgtValid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input int a, input logic [63:0] d, input logic w64);
    @(negedge clk); wrEn = 1; addr = ADDR_W'(a); wrData = d; is64 = w64;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic busRd(input int a, input logic w64, output logic [63:0] v);
    @(negedge clk); rdEn = 1; addr = ADDR_W'(a); is64 = w64;
    @(negedge clk); rdEn = 0; v = rdData;
  endtask

  function automatic logic [2:0] tgtOf(input int n);
    return {tgtValid[n-NUM_PRIV], tgtIdx[(n-NUM_PRIV)*IDX_W +: IDX_W]};
  endfunction

  task automatic tReset();
    logic [63:0] v;
    chk("R10 rdData after reset", rdData, 64'h0);
    // zero affinity matches core1
    chk("R10 target irq32", 64'(tgtOf(32)), 64'h5);
    chk("R10 target irq63", 64'(tgtOf(63)), 64'h5);
    busRd(40*8, 1, v);
    chk("R10 affinity zero", v, 64'h0);
  endtask

  task automatic tWriteRead();
    logic [63:0] v;
    busWr(40*8, 64'hFFFF_FFFF_FF0A_0B0C, 1);
    busRd(40*8, 1, v);
    chk("R4 only 24 bits stored", v, 64'h0A0B0C);
    chk("R7 lowest of cores 2,3", 64'(tgtOf(40)), 64'h6);
    busWr(33*8, 64'h0000_0000_0001_0203, 0);
    chk("R5 target core0", 64'(tgtOf(33)), 64'h4);
    busRd(33*8, 0, v);
    chk("R1 readback irq33", v, 64'h010203);
    busRd(40*8, 1, v);
    chk("R1 irq40 unaffected", v, 64'h0A0B0C);
  endtask

  task automatic tNoMatch();
    busWr(50*8, 64'h123456, 0);
    chk("R6 no match invalid", 64'(tgtValid[50-NUM_PRIV]), 64'h0);
  endtask

  task automatic tByteExtract();
    logic [63:0] v;
    busRd(40*8 + 1, 0, v);
    chk("R8 offset 1", v, 64'h0A0B);
    busRd(40*8 + 2, 1, v);
    chk("R8 offset 2", v, 64'h0A);
  endtask

  task automatic tUpper();
    logic [63:0] v;
    busWr(40*8 + 4, 64'h77, 0);
    busRd(40*8, 1, v);
    chk("R3 upper write ignored", v, 64'h0A0B0C);
    chk("R3 target unchanged", 64'(tgtOf(40)), 64'h6);
    busRd(40*8 + 4, 0, v);
    chk("R3 upper reads zero", v, 64'h0);
  endtask

  task automatic tPrivate();
    logic [63:0] v;
    busWr(5*8, 64'h010203, 0);
    busRd(5*8, 0, v);
    chk("R2 private reads zero", v, 64'h0);
    busRd(32*8, 1, v);
    chk("R2 irq32 untouched", v, 64'h0);
    chk("R2 irq32 target", 64'(tgtOf(32)), 64'h5);
  endtask

  task automatic tBeyond();
    logic [63:0] v;
    busWr(96*8, 64'h010203, 1);
    busRd(96*8, 1, v);
    chk("R9 beyond reads zero", v, 64'h0);
    busRd(32*8, 1, v);
    chk("R9 irq32 untouched", v, 64'h0);
    chk("R9 irq32 target", 64'(tgtOf(32)), 64'h5);
  endtask

  task automatic tReadHold();
    logic [63:0] v;
    busRd(33*8, 1, v);
    busWr(33*8, 64'h0A0B0C, 1);
    @(negedge clk);
    chk("R11 rdData holds", rdData, 64'h010203);
    busRd(33*8, 1, v);
    chk("R11 new value after read", v, 64'h0A0B0C);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tWriteRead();
    tNoMatch();
    tByteExtract();
    tUpper();
    tPrivate();
    tBeyond();
    tReadHold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule